// File: doc/BRIEF.md
# Two-Dimensional Blit Address Sequencer

This block is the control sequencer of a word-oriented bit-block transfer engine. It walks a rectangular destination region one line at a time. For every destination word it issues a fixed series of requests on a word-addressed request/acknowledge memory port. The series is an optional extra source read at the start of a line, then a source read, then a destination read when needed, and finally the destination write. Alongside those requests it drives the control strobes, edge mask and halftone line index that the shift/logic datapath beside it consumes.

The source and destination addresses walk independently. Each has its own signed horizontal and vertical byte increments. Horizontal and vertical word counters track the position in the region. Two per-line flags shape the source traffic. The first fetches one extra source word at the start of each line to prime the datapath's shift buffer. The second drops the last source read of each line, which forces a read-modify-write of the last destination word. Software loads a configuration while the block is idle and then sets the busy bit. Clearing busy pauses the walk. Setting it again resumes from the exact point where it stopped.

Top module: `blit_seq`

## Requirements
- R1: `cfg_x_count` is the number of destination words per line and `cfg_y_count` the number of lines; a loaded value of 0 stands for 65536 in either count.
- R2: Addresses are word addresses. Increments are byte offsets whose LSB is dropped, so the word step is the increment shifted right arithmetically by one. Each source fetch, the extra one included, adds the source horizontal step, or the source vertical step when the remaining X count is 1. Each destination write does the same with the destination steps. `rb_src_addr` and `rb_dst_addr` always show the next address to be used.
- R3: The remaining X count (`rb_x_left`) drops by one on every destination write. At the end of a line it reloads to the initial value. The remaining Y count (`rb_y_left`) drops by one at each line end, and busy clears when it reaches zero.
- R4: The write mask `dp_mask` is `cfg_mask_first` on the first write of a line and `cfg_mask_last` on the last one. Every other write uses `cfg_mask_mid`. A one-word line uses `cfg_mask_first`.
- R5: With `cfg_xtra_rd` set, every line begins with one additional source read before that line's first regular source read.
- R6: With `cfg_skip_last` set, the last source read of each line is not requested. Instead `dp_src_shift` pulses for one cycle with no request outstanding, and the next request is a destination read of that line's last word, whatever its mask.
- R7: A destination read is issued only when the combine code depends on the destination, or the active mask is not all ones, or R6 applies. The code bits 3..0 give the result for (src,dst) = (0,0),(0,1),(1,0),(1,1), and it depends on the destination when bit3≠bit2 or bit1≠bit0.
- R8: `dp_line_idx` starts at `cfg_line_idx` and changes at every line end, wrapping through zero. It steps up by one when the destination vertical increment has a clear sign bit and down by one when that sign bit is set.
- R9: `mem_kind` encodes 0 = source read, 1 = destination read, 2 = destination write. The order per word is: extra source read (R5), then source read, then destination read (R7), then write. A request keeps its address and kind until `mem_ack` is seen with it.
- R10: Writing `busy_wr` with `busy_wdata`=1 starts or resumes the walk. Writing it with 0 stops it at the current step, with no request issued until it resumes. A write of 1 when the remaining Y count is zero leaves busy clear.
- R11: `cfg_load` is ignored while busy.
- R12: After reset, busy, `mem_req` and the remaining counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load all configuration fields (idle only) |
| cfg_src_addr | input | ADDR_W | Initial source word address |
| cfg_dst_addr | input | ADDR_W | Initial destination word address |
| cfg_src_xinc | input | INC_W | Source step between words, bytes, signed |
| cfg_src_yinc | input | INC_W | Source step at line end, bytes, signed |
| cfg_dst_xinc | input | INC_W | Destination step between words, bytes, signed |
| cfg_dst_yinc | input | INC_W | Destination step at line end, bytes, signed |
| cfg_x_count | input | CNT_W | Words per line (0 = 65536) |
| cfg_y_count | input | CNT_W | Lines (0 = 65536) |
| cfg_mask_first | input | DATA_W | Mask of the first write in a line |
| cfg_mask_mid | input | DATA_W | Mask of inner writes |
| cfg_mask_last | input | DATA_W | Mask of the last write in a line |
| cfg_op | input | 4 | Source/destination combine code |
| cfg_xtra_rd | input | 1 | Extra source read at line start |
| cfg_skip_last | input | 1 | Drop last source read of each line |
| cfg_line_idx | input | IDX_W | Initial halftone line index |
| busy_wr | input | 1 | Busy bit write strobe |
| busy_wdata | input | 1 | Value written to busy |
| busy | output | 1 | Transfer active |
| mem_req | output | 1 | Memory request |
| mem_kind | output | 2 | 0 source read, 1 destination read, 2 destination write |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_ack | input | 1 | Request accepted this cycle |
| dp_mask | output | DATA_W | Active write mask |
| dp_line_idx | output | IDX_W | Current halftone line index |
| dp_src_take | output | 1 | Source word accepted into the shift buffer |
| dp_src_shift | output | 1 | Buffer half-shift with no fetch |
| dp_dst_take | output | 1 | Destination word accepted |
| rb_src_addr | output | ADDR_W | Next source address |
| rb_dst_addr | output | ADDR_W | Next destination address |
| rb_x_left | output | CNT_W+1 | Words left in the current line |
| rb_y_left | output | CNT_W+1 | Lines left |

## Verification
The bench targets the line edges. One-word lines must take the vertical step and the first mask on both source fetches. A design that tests for "last" before "first" would pick the wrong mask there. The skip-last case is driven with an all-ones last mask and a code that ignores the destination. A sequencer that forgot the forced read-modify-write would emit a bare write and lose the shift pulse. A negative destination vertical increment from index 0 catches a line index that does not wrap downward. A pause in the middle of a word, with a stray configuration load during a run, catches a design that restarts the line or takes new addresses. A 65536-word line catches a count that treats 0 as empty.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    typedef enum logic [1:0] {
        PH_XTRA = 2'd0,   // priming source fetch at line start
        PH_SRC  = 2'd1,   // regular source fetch (or skip cycle)
        PH_DRD  = 2'd2,   // destination read for read-modify-write
        PH_DWR  = 2'd3    // destination write
    } phase_e;

    localparam logic [1:0] KIND_SRC = 2'd0;
    localparam logic [1:0] KIND_DRD = 2'd1;
    localparam logic [1:0] KIND_DWR = 2'd2;

endpackage

// File: rtl/blit_addr_step.sv
module blit_addr_step #(
    parameter int ADDR_W = 23,
    parameter int INC_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [INC_W-1:0]  inc_x,
    input  logic [INC_W-1:0]  inc_y,
    input  logic              use_y,
    output logic [ADDR_W-1:0] next_addr
);
    logic [INC_W-1:0]         inc_sel;
    logic signed [ADDR_W-1:0] inc_wide;
    logic [ADDR_W-1:0]        word_step;

    always_comb begin
        inc_sel   = use_y ? inc_y : inc_x;
        inc_wide  = ADDR_W'($signed(inc_sel));
        word_step = inc_wide >>> 1;          // byte offset to word offset
        next_addr = addr + word_step;
    end
endmodule

// File: rtl/blit_edge_sel.sv
module blit_edge_sel #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic [CNT_W:0]    x_left,
    input  logic [CNT_W:0]    x_init,
    input  logic [DATA_W-1:0] mask_first,
    input  logic [DATA_W-1:0] mask_mid,
    input  logic [DATA_W-1:0] mask_last,
    input  logic [3:0]        op,
    input  logic              skip_last,
    output logic [DATA_W-1:0] mask,
    output logic              is_last,
    output logic              need_dst_rd
);
    logic is_first;
    logic op_uses_dst;

    always_comb begin
        is_first    = (x_left == x_init);
        is_last     = (x_left == {{CNT_W{1'b0}}, 1'b1});
        // first has priority so a one-word line takes the first mask
        if (is_first)      mask = mask_first;
        else if (is_last)  mask = mask_last;
        else               mask = mask_mid;
        op_uses_dst = (op[3] ^ op[2]) | (op[1] ^ op[0]);
        need_dst_rd = op_uses_dst | ~(&mask) | (is_last & skip_last);
    end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_seq_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int INC_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [INC_W-1:0]  cfg_src_xinc,
    input  logic [INC_W-1:0]  cfg_src_yinc,
    input  logic [INC_W-1:0]  cfg_dst_xinc,
    input  logic [INC_W-1:0]  cfg_dst_yinc,
    input  logic [CNT_W-1:0]  cfg_x_count,
    input  logic [CNT_W-1:0]  cfg_y_count,
    input  logic [DATA_W-1:0] cfg_mask_first,
    input  logic [DATA_W-1:0] cfg_mask_mid,
    input  logic [DATA_W-1:0] cfg_mask_last,
    input  logic [3:0]        cfg_op,
    input  logic              cfg_xtra_rd,
    input  logic              cfg_skip_last,
    input  logic [IDX_W-1:0]  cfg_line_idx,
    input  logic              busy_wr,
    input  logic              busy_wdata,
    output logic              busy,
    output logic              mem_req,
    output logic [1:0]        mem_kind,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic [DATA_W-1:0] dp_mask,
    output logic [IDX_W-1:0]  dp_line_idx,
    output logic              dp_src_take,
    output logic              dp_src_shift,
    output logic              dp_dst_take,
    output logic [ADDR_W-1:0] rb_src_addr,
    output logic [ADDR_W-1:0] rb_dst_addr,
    output logic [CNT_W:0]    rb_x_left,
    output logic [CNT_W:0]    rb_y_left
);
    localparam int XW = CNT_W + 1;

    typedef struct packed {
        logic              busy;
        phase_e            phase;
        logic [ADDR_W-1:0] src_addr;
        logic [ADDR_W-1:0] dst_addr;
        logic [XW-1:0]     x_left;
        logic [XW-1:0]     y_left;
        logic [XW-1:0]     x_init;
        logic [IDX_W-1:0]  line_idx;
        logic [INC_W-1:0]  sxi;
        logic [INC_W-1:0]  syi;
        logic [INC_W-1:0]  dxi;
        logic [INC_W-1:0]  dyi;
        logic [DATA_W-1:0] m_first;
        logic [DATA_W-1:0] m_mid;
        logic [DATA_W-1:0] m_last;
        logic [3:0]        op;
        logic              xtra;
        logic              skip_last;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [XW-1:0] widen_count(input logic [CNT_W-1:0] c);
        logic [XW-1:0] r;
        r = {1'b0, c};
        if (c == '0) r = {1'b1, {CNT_W{1'b0}}};
        return r;
    endfunction

    logic [DATA_W-1:0] mask_w;
    logic              last_w;
    logic              need_rd_w;
    logic [ADDR_W-1:0] src_next_w;
    logic [ADDR_W-1:0] dst_next_w;
    logic              skip_now;
    logic              hs;

    blit_edge_sel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_edge (
        .x_left      (st_q.x_left),
        .x_init      (st_q.x_init),
        .mask_first  (st_q.m_first),
        .mask_mid    (st_q.m_mid),
        .mask_last   (st_q.m_last),
        .op          (st_q.op),
        .skip_last   (st_q.skip_last),
        .mask        (mask_w),
        .is_last     (last_w),
        .need_dst_rd (need_rd_w)
    );

    blit_addr_step #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_src_step (
        .addr      (st_q.src_addr),
        .inc_x     (st_q.sxi),
        .inc_y     (st_q.syi),
        .use_y     (last_w),
        .next_addr (src_next_w)
    );

    blit_addr_step #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_dst_step (
        .addr      (st_q.dst_addr),
        .inc_x     (st_q.dxi),
        .inc_y     (st_q.dyi),
        .use_y     (last_w),
        .next_addr (dst_next_w)
    );

    // memory and datapath side, decoded from the registered state
    always_comb begin
        skip_now     = st_q.busy && (st_q.phase == PH_SRC) && last_w && st_q.skip_last;
        mem_req      = st_q.busy && !((st_q.phase == PH_SRC) && last_w && st_q.skip_last);
        hs           = mem_req && mem_ack;
        unique case (st_q.phase)
            PH_DRD:  mem_kind = KIND_DRD;
            PH_DWR:  mem_kind = KIND_DWR;
            default: mem_kind = KIND_SRC;
        endcase
        mem_addr     = (st_q.phase == PH_DRD || st_q.phase == PH_DWR) ? st_q.dst_addr
                                                                      : st_q.src_addr;
        dp_src_take  = hs && (st_q.phase == PH_XTRA || st_q.phase == PH_SRC);
        dp_dst_take  = hs && (st_q.phase == PH_DRD);
        dp_src_shift = skip_now;
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_XTRA: begin
                if (hs) begin
                    st_d.src_addr = src_next_w;
                    st_d.phase    = PH_SRC;
                end
            end
            PH_SRC: begin
                if (skip_now) begin
                    st_d.phase = PH_DRD;
                end else if (hs) begin
                    st_d.src_addr = src_next_w;
                    st_d.phase    = need_rd_w ? PH_DRD : PH_DWR;
                end
            end
            PH_DRD: begin
                if (hs) st_d.phase = PH_DWR;
            end
            PH_DWR: begin
                if (hs) begin
                    st_d.dst_addr = dst_next_w;
                    if (last_w) begin
                        st_d.x_left   = st_q.x_init;
                        st_d.y_left   = st_q.y_left - 1'b1;
                        st_d.line_idx = st_q.dyi[INC_W-1] ? st_q.line_idx - 1'b1
                                                          : st_q.line_idx + 1'b1;
                        st_d.phase    = st_q.xtra ? PH_XTRA : PH_SRC;
                        if (st_q.y_left == {{CNT_W{1'b0}}, 1'b1}) st_d.busy = 1'b0;
                    end else begin
                        st_d.x_left = st_q.x_left - 1'b1;
                        st_d.phase  = PH_SRC;
                    end
                end
            end
            default: ;
        endcase

        if (cfg_load && !st_q.busy) begin
            st_d.src_addr  = cfg_src_addr;
            st_d.dst_addr  = cfg_dst_addr;
            st_d.sxi       = cfg_src_xinc;
            st_d.syi       = cfg_src_yinc;
            st_d.dxi       = cfg_dst_xinc;
            st_d.dyi       = cfg_dst_yinc;
            st_d.x_init    = widen_count(cfg_x_count);
            st_d.x_left    = widen_count(cfg_x_count);
            st_d.y_left    = widen_count(cfg_y_count);
            st_d.m_first   = cfg_mask_first;
            st_d.m_mid     = cfg_mask_mid;
            st_d.m_last    = cfg_mask_last;
            st_d.op        = cfg_op;
            st_d.xtra      = cfg_xtra_rd;
            st_d.skip_last = cfg_skip_last;
            st_d.line_idx  = cfg_line_idx;
            st_d.phase     = cfg_xtra_rd ? PH_XTRA : PH_SRC;
        end

        if (busy_wr) st_d.busy = busy_wdata && (st_d.y_left != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_SRC;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign dp_mask     = mask_w;
    assign dp_line_idx = st_q.line_idx;
    assign rb_src_addr = st_q.src_addr;
    assign rb_dst_addr = st_q.dst_addr;
    assign rb_x_left   = st_q.x_left;
    assign rb_y_left   = st_q.y_left;
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
    parameter int ADDR_W = 23,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_wr,
    input logic              busy_wdata,
    input logic              busy,
    input logic              mem_req,
    input logic [1:0]        mem_kind,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              dp_src_shift,
    input logic [IDX_W-1:0]  dp_line_idx,
    input logic [CNT_W:0]    rb_x_left,
    input logic [CNT_W:0]    rb_y_left
);
    assert_req_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !(busy_wr && !busy_wdata))
        |=> (mem_req && $stable(mem_addr) && $stable(mem_kind)));

    assert_skip_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_src_shift |-> !mem_req);

    assert_skip_then_rmw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_src_shift && !(busy_wr && !busy_wdata)) |=> (mem_req && mem_kind == 2'd1));

    assert_xcount_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_kind == 2'd2 && rb_x_left != 1)
        |=> (rb_x_left == $past(rb_x_left) - 1'b1));

    assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_kind == 2'd2 && rb_x_left == 1)
        |=> ((dp_line_idx == $past(dp_line_idx) + 1'b1) ||
             (dp_line_idx == $past(dp_line_idx) - 1'b1)));

    assert_done_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(busy_wr)) |-> (rb_y_left == '0));
endmodule

bind blit_seq blit_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_blit_seq.sv
module tb_blit_seq;
    localparam int ADDR_W = 23;
    localparam int INC_W  = 16;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 4;
    localparam int AMASK  = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cfg_load, busy_wr, busy_wdata, busy, mem_req, mem_ack;
    logic [ADDR_W-1:0] cfg_src_addr, cfg_dst_addr, mem_addr, rb_src_addr, rb_dst_addr;
    logic [INC_W-1:0]  cfg_src_xinc, cfg_src_yinc, cfg_dst_xinc, cfg_dst_yinc;
    logic [CNT_W-1:0]  cfg_x_count, cfg_y_count;
    logic [DATA_W-1:0] cfg_mask_first, cfg_mask_mid, cfg_mask_last, dp_mask;
    logic [3:0]        cfg_op;
    logic              cfg_xtra_rd, cfg_skip_last;
    logic [IDX_W-1:0]  cfg_line_idx, dp_line_idx;
    logic [1:0]        mem_kind;
    logic              dp_src_take, dp_src_shift, dp_dst_take;
    logic [CNT_W:0]    rb_x_left, rb_y_left;

    blit_seq dut (.*);

    int checks = 0, errors = 0, cyc = 0, ack_mode = 0;
    int q_kind[$], q_addr[$], q_mask[$], q_idx[$];
    int exp_sa, exp_da, exp_xn;
    bit m_busy = 1'b0, done_pend = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wstep(input logic [15:0] v);
        return int'($signed(v)) >>> 1;
    endfunction

    // expected request list built from the requirements
    task automatic build_expect();
        int xn, yn, sa, da, idx, m;
        bit opd;
        xn  = (cfg_x_count == 0) ? 65536 : int'(cfg_x_count);
        yn  = (cfg_y_count == 0) ? 65536 : int'(cfg_y_count);
        sa  = int'(cfg_src_addr); da = int'(cfg_dst_addr); idx = int'(cfg_line_idx);
        opd = (cfg_op[3] ^ cfg_op[2]) | (cfg_op[1] ^ cfg_op[0]);
        for (int l = 0; l < yn; l++) begin
            for (int w = 0; w < xn; w++) begin
                bit first, last;
                first = (w == 0); last = (w == xn - 1);
                if (first && cfg_xtra_rd) begin            // R5
                    q_kind.push_back(0); q_addr.push_back(sa); q_mask.push_back(0); q_idx.push_back(0);
                    sa = (sa + wstep(xn == 1 ? cfg_src_yinc : cfg_src_xinc)) & AMASK;
                end
                if (last && cfg_skip_last) begin           // R6
                    q_kind.push_back(3); q_addr.push_back(0); q_mask.push_back(0); q_idx.push_back(0);
                end else begin
                    q_kind.push_back(0); q_addr.push_back(sa); q_mask.push_back(0); q_idx.push_back(0);
                    sa = (sa + wstep(last ? cfg_src_yinc : cfg_src_xinc)) & AMASK;
                end
                m = first ? int'(cfg_mask_first) : (last ? int'(cfg_mask_last) : int'(cfg_mask_mid));
                if (opd || m != 16'hffff || (last && cfg_skip_last)) begin   // R7
                    q_kind.push_back(1); q_addr.push_back(da); q_mask.push_back(0); q_idx.push_back(0);
                end
                q_kind.push_back(2); q_addr.push_back(da); q_mask.push_back(m); q_idx.push_back(idx);
                da = (da + wstep(last ? cfg_dst_yinc : cfg_dst_xinc)) & AMASK;
            end
            idx = cfg_dst_yinc[15] ? ((idx + 15) & 15) : ((idx + 1) & 15);
        end
        exp_sa = sa; exp_da = da; exp_xn = xn;
    endtask

    task automatic pop_cmp(input int kind, input int addr);
        int k, a, m, ix;
        if (q_kind.size() == 0) begin
            chk(1'b0, "R9", "unexpected event", kind, 99);
            return;
        end
        k = q_kind.pop_front(); a = q_addr.pop_front(); m = q_mask.pop_front(); ix = q_idx.pop_front();
        chk(k == kind, "R9", "event kind", kind, k);
        if (k == kind && k != 3) chk(a == addr, "R2", "address", addr, a);
        if (k == kind && k == 2) begin
            chk(m == int'(dp_mask), "R4", "write mask", dp_mask, m);
            chk(ix == int'(dp_line_idx), "R8", "line index", dp_line_idx, ix);
        end
        if (q_kind.size() == 0) done_pend = 1'b1;
    endtask

    // monitor and acknowledge driver, away from the active edge
    always @(negedge clk) begin
        bit ack;
        cyc++;
        done_pend = 1'b0;
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else begin
            chk(busy == m_busy, "R10", "busy", busy, m_busy);
            if (!m_busy && mem_req) chk(1'b0, "R10", "request while stopped", 1, 0);
            ack = mem_req && (ack_mode == 0 || (cyc % 3) != 0);
            if (dp_src_shift) pop_cmp(3, 0);
            if (ack) pop_cmp(int'(mem_kind), int'(mem_addr));
            mem_ack = ack;
        end
    end

    always @(posedge clk) begin
        if (!rst_n)         m_busy <= 1'b0;
        else if (busy_wr)   m_busy <= busy_wdata && (q_kind.size() != 0);
        else if (done_pend) m_busy <= 1'b0;
    end

    always @(posedge clk) begin
        if (cyc > 195000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_cfg(input int sa, input int da, input int sxi, input int syi,
                           input int dxi, input int dyi, input int xc, input int yc,
                           input int m1, input int m2, input int m3, input int op,
                           input bit xr, input bit sk, input int idx);
        cfg_src_addr = sa[ADDR_W-1:0]; cfg_dst_addr = da[ADDR_W-1:0];
        cfg_src_xinc = sxi[15:0]; cfg_src_yinc = syi[15:0];
        cfg_dst_xinc = dxi[15:0]; cfg_dst_yinc = dyi[15:0];
        cfg_x_count = xc[15:0]; cfg_y_count = yc[15:0];
        cfg_mask_first = m1[15:0]; cfg_mask_mid = m2[15:0]; cfg_mask_last = m3[15:0];
        cfg_op = op[3:0]; cfg_xtra_rd = xr; cfg_skip_last = sk; cfg_line_idx = idx[3:0];
    endtask

    task automatic start_xfer();
        @(negedge clk);
        cfg_load = 1'b1;
        build_expect();
        @(negedge clk);
        cfg_load = 1'b0; busy_wr = 1'b1; busy_wdata = 1'b1;
        @(negedge clk);
        busy_wr = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic check_end(input string tag);
        chk(q_kind.size() == 0, tag, "events left", q_kind.size(), 0);
        chk(int'(rb_src_addr) == exp_sa, "R2", "source readback", rb_src_addr, exp_sa);
        chk(int'(rb_dst_addr) == exp_da, "R2", "destination readback", rb_dst_addr, exp_da);
        chk(int'(rb_x_left) == exp_xn, "R3", "x count reload", rb_x_left, exp_xn);
        chk(rb_y_left == 0, "R3", "lines left", rb_y_left, 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; busy_wr = 1'b0; busy_wdata = 1'b0; mem_ack = 1'b0;
        set_cfg(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12", "busy after reset", busy, 0);
        chk(mem_req == 1'b0, "R12", "request after reset", mem_req, 0);
        chk(rb_y_left == 0 && rb_x_left == 0, "R12", "counts after reset", rb_y_left, 0);
        rst_n = 1'b1;

        // A: plain copy, no destination reads, mixed increments (R2 R3 R7 R9)
        ack_mode = 0;
        set_cfg('h1000, 'h2000, 2, -8, 4, 160, 3, 2, 'hffff, 'hffff, 'hffff, 3, 0, 0, 5);
        start_xfer(); wait_done(); check_end("R3");

        // B: extra read + skip last, partial masks, xor, index down through 0, slow ack (R4 R5 R6 R8 R11)
        ack_mode = 1;
        set_cfg('h0100, 'h7ff0, 2, 10, 2, -6, 4, 3, 'h00ff, 'hffff, 'hff00, 6, 1, 1, 0);
        start_xfer();
        repeat (7) @(negedge clk);
        cfg_src_addr = 'h55555; cfg_dst_addr = 'h33333; cfg_x_count = 9; cfg_load = 1'b1;  // R11
        @(negedge clk);
        cfg_load = 1'b0;
        wait_done(); check_end("R11");

        // C: one-word lines with extra read, index wraps upward (R2 R4 R5 R8)
        ack_mode = 0;
        set_cfg('h4000, 'h5000, 100, 6, 100, 40, 1, 3, 'hffff, 'h0000, 'h0000, 0, 1, 0, 14);
        start_xfer(); wait_done(); check_end("R5");

        // D: skip last with all-ones mask and code ignoring destination (R6 R7)
        set_cfg('h0200, 'h0300, 2, 2, 2, 2, 2, 2, 'hffff, 'hffff, 'hffff, 'hc, 0, 1, 3);
        start_xfer(); wait_done(); check_end("R6");

        // E: pause and resume, then start with no lines left (R10)
        ack_mode = 1;
        set_cfg('h0010, 'h0020, 2, 2, 2, 2, 4, 3, 'hffff, 'hffff, 'hffff, 5, 0, 0, 7);
        start_xfer();
        repeat (10) @(negedge clk);
        busy_wr = 1'b1; busy_wdata = 1'b0;
        @(negedge clk);
        busy_wr = 1'b0;
        begin
            logic [CNT_W:0] yl, xl;
            yl = rb_y_left; xl = rb_x_left;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                chk(mem_req == 1'b0, "R10", "request during pause", mem_req, 0);
            end
            chk(rb_y_left == yl && rb_x_left == xl, "R10", "state held in pause", rb_x_left, xl);
        end
        busy_wr = 1'b1; busy_wdata = 1'b1;
        @(negedge clk);
        busy_wr = 1'b0;
        wait_done(); check_end("R10");
        busy_wr = 1'b1; busy_wdata = 1'b1;
        @(negedge clk);
        busy_wr = 1'b0;
        chk(busy == 1'b0, "R10", "start with no lines", busy, 0);
        @(negedge clk);
        chk(mem_req == 1'b0, "R10", "no request with no lines", mem_req, 0);

        // F: x count of zero means 65536 words (R1)
        ack_mode = 0;
        set_cfg('h10000, 'h20000, 2, 2, 2, 2, 0, 1, 'hffff, 'hffff, 'hffff, 0, 0, 0, 0);
        start_xfer(); wait_done();
        chk(exp_xn == 65536, "R1", "expected words", exp_xn, 65536);
        check_end("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule